// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits at the front of a single-issue pipeline that keeps one program counter per hardware thread. Each cycle it decides which thread, if any, supplies the next fetch, and it presents that thread's ID and its current PC. A mode input chooses between two switching policies.

In fine-grained mode the selection can move to a different thread on every clock. Candidates are scanned in round-robin order from a pointer, and any thread flagged as stalled is passed over in the same cycle. With two or more threads ready, back-to-back fetches come from different threads, so a load and the instruction that uses its result are spaced apart by another thread's work. In coarse-grained mode one thread owns fetch until a long-latency miss is reported. The block then stops fetching, asks the pipeline to drain, waits for the pipeline-empty indication, and refills from the next ready thread. Because every thread owns its PC register, no state is copied at a switch. Fine-grained switches therefore cost nothing, and a coarse switch costs only the drain and refill time.

The controller has four states. FINE does per-cycle round-robin. HOLD runs one owning thread. DRAIN requests a pipeline flush. SWAP picks the new owner. The transitions are:
- FINE→HOLD when coarse mode is selected.
- HOLD→DRAIN on a miss.
- HOLD→FINE when fine mode is selected.
- DRAIN→SWAP once the pipeline is empty.
- SWAP→HOLD or SWAP→FINE, depending on the mode, once a ready thread is found.

Top module: `mt_fetch_sel`

## Requirements
- R1: After reset every thread's PC equals START_BASE + thread_index × START_STRIDE, the controller is in FINE, the round-robin pointer is 0 (thread 0 is the first candidate), and the drain request is low.
- R2: In FINE, fetch_vld is high when any thread is ready, and fetch_tid is the first ready thread found scanning upward from the pointer with wrap at N_THREADS. The pointer then moves to the granted thread plus one, wrapping to 0. A thread ready flag of 0 means stalled.
- R3: In FINE with no thread ready, fetch_vld is low, and the pointer keeps its value so the next grant resumes from the same place.
- R4: fetch_pc is the current PC of fetch_tid. Each grant advances that thread's PC by ILEN_BYTES on the next edge, and leaves every other thread's PC unchanged.
- R5: When redir_vld is high, redir_pc is loaded into thread redir_tid at the next edge. This load wins over a same-cycle increment of that thread, and a fetch of that thread in the same cycle still shows the old PC. A redir_tid of N_THREADS or above changes nothing.
- R6: In FINE, miss_evt has no effect: the selection is unchanged and drain_req stays low.
- R7: In HOLD, fetch_tid is always the owning thread. When that thread is not ready, fetch_vld is low and no switch occurs.
- R8: In HOLD, miss_evt drops fetch_vld in that cycle and moves the controller to DRAIN. In DRAIN, drain_req is high and fetch_vld is low, up to and including the cycle in which pipe_empty is seen.
- R9: In SWAP (the cycle after pipe_empty was seen in DRAIN), drain_req is low and the first ready thread scanning from owner plus one is fetched and becomes the owner, with the old owner considered last. If no thread is ready, fetch_vld stays low and SWAP repeats.
- R10: When coarse_mode is high in FINE, the thread granted in that cycle becomes the owner, or the pointer's thread if nothing was granted, and HOLD follows. When coarse_mode is low in HOLD without a miss, FINE follows with the pointer set to owner plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 1 selects coarse-grained switching, 0 selects fine-grained |
| thr_ready | input | N_THREADS | Per-thread ready flag, 0 marks a stalled thread |
| miss_evt | input | 1 | Long-latency miss reported for the running thread |
| pipe_empty | input | 1 | Pipeline holds no in-flight instructions |
| redir_vld | input | 1 | Load a new PC into one thread |
| redir_tid | input | TID_W | Thread whose PC is loaded |
| redir_pc | input | PC_W | PC value to load |
| fetch_vld | output | 1 | A fetch is issued this cycle |
| fetch_tid | output | TID_W | Thread supplying the fetch |
| fetch_pc | output | PC_W | PC of the selected thread |
| drain_req | output | 1 | Request to empty or freeze the pipeline |

## Verification
The bench builds the block with three threads, 16-bit PCs, a 4-byte step, and start addresses 0x0100 apart by 0x0040. Three threads make the round-robin wrap fall on a count that is not a power of two. That leaves thread-ID code 3 unused, so a redirect to a nonexistent thread can be aimed at it. The small thread count lets random ready patterns often produce the all-stalled case, swaps where only the old owner is ready, and redirects that collide with a grant to the same thread.

// File: rtl/mt_fetch_pkg.sv
package mt_fetch_pkg;

    // Controller states of the thread selector
    typedef enum logic [1:0] {
        SEL_FINE  = 2'd0,   // per-cycle round-robin interleave
        SEL_HOLD  = 2'd1,   // one thread owns fetch (coarse)
        SEL_DRAIN = 2'd2,   // waiting for the pipeline to empty
        SEL_SWAP  = 2'd3    // choosing the next owner
    } sel_state_e;

endpackage

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = $clog2(N_THREADS)
) (
    input  logic [N_THREADS-1:0] req,
    input  logic [TID_W-1:0]     start,
    output logic                 found,
    output logic [TID_W-1:0]     idx
);

    localparam int CW = TID_W + 1;

    // Scan from the highest offset down so the lowest offset wins.
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int k = N_THREADS - 1; k >= 0; k--) begin
            logic [CW-1:0] pos;
            pos = {1'b0, start} + CW'(k);
            if (pos >= CW'(N_THREADS)) begin
                pos = pos - CW'(N_THREADS);
            end
            if (req[pos[TID_W-1:0]]) begin
                found = 1'b1;
                idx   = pos[TID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
    parameter int              N_THREADS    = 4,
    parameter int              TID_W        = $clog2(N_THREADS),
    parameter int              PC_W         = 32,
    parameter int              ILEN_BYTES   = 4,
    parameter logic [PC_W-1:0] START_BASE   = '0,
    parameter logic [PC_W-1:0] START_STRIDE = PC_W'(32'h0000_1000)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inc_vld,
    input  logic [TID_W-1:0]          inc_tid,
    input  logic                      redir_vld,
    input  logic [TID_W-1:0]          redir_tid,
    input  logic [PC_W-1:0]           redir_pc,
    input  logic [TID_W-1:0]          rd_tid,
    output logic [PC_W-1:0]           rd_pc,
    output logic [N_THREADS*PC_W-1:0] pc_flat
);

    logic [PC_W-1:0] pc_q [N_THREADS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_THREADS; i++) begin
                pc_q[i] <= START_BASE + PC_W'(i) * START_STRIDE;
            end
        end else begin
            for (int i = 0; i < N_THREADS; i++) begin
                if (redir_vld && (redir_tid == TID_W'(i))) begin
                    pc_q[i] <= redir_pc;
                end else if (inc_vld && (inc_tid == TID_W'(i))) begin
                    pc_q[i] <= pc_q[i] + PC_W'(ILEN_BYTES);
                end
            end
        end
    end

    always_comb begin
        rd_pc = '0;
        if (32'(rd_tid) < N_THREADS) begin
            rd_pc = pc_q[rd_tid];
        end
    end

    for (genvar g = 0; g < N_THREADS; g++) begin : g_flat
        assign pc_flat[g*PC_W +: PC_W] = pc_q[g];
    end

endmodule

// File: rtl/mt_sel_fsm.sv
module mt_sel_fsm
    import mt_fetch_pkg::*;
#(
    parameter int N_THREADS = 4,
    parameter int TID_W     = $clog2(N_THREADS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coarse_mode,
    input  logic [N_THREADS-1:0] thr_ready,
    input  logic                 miss_evt,
    input  logic                 pipe_empty,
    input  logic                 pick_found,
    input  logic [TID_W-1:0]     pick_idx,
    output logic [TID_W-1:0]     pick_start,
    output logic                 fetch_vld,
    output logic [TID_W-1:0]     fetch_tid,
    output logic                 drain_req,
    output sel_state_e           state_o
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(N_THREADS - 1);

    sel_state_e       state_q, state_d;
    logic [TID_W-1:0] rr_q, rr_d;
    logic [TID_W-1:0] cur_q, cur_d;

    function automatic logic [TID_W-1:0] tid_inc(input logic [TID_W-1:0] t);
        return (t == LAST_TID) ? '0 : t + TID_W'(1);
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_FINE;
            rr_q    <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            rr_q    <= rr_d;
            cur_q   <= cur_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        rr_d    = rr_q;
        cur_d   = cur_q;
        unique case (state_q)
            SEL_FINE: begin
                if (pick_found) begin
                    rr_d = tid_inc(pick_idx);
                end
                if (coarse_mode) begin
                    state_d = SEL_HOLD;
                    cur_d   = pick_found ? pick_idx : rr_q;
                end
            end
            SEL_HOLD: begin
                if (miss_evt) begin
                    state_d = SEL_DRAIN;
                end else if (!coarse_mode) begin
                    state_d = SEL_FINE;
                    rr_d    = tid_inc(cur_q);
                end
            end
            SEL_DRAIN: begin
                if (pipe_empty) begin
                    state_d = SEL_SWAP;
                end
            end
            SEL_SWAP: begin
                if (pick_found) begin
                    cur_d   = pick_idx;
                    rr_d    = tid_inc(pick_idx);
                    state_d = coarse_mode ? SEL_HOLD : SEL_FINE;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        fetch_vld  = 1'b0;
        fetch_tid  = cur_q;
        drain_req  = 1'b0;
        pick_start = rr_q;
        unique case (state_q)
            SEL_FINE: begin
                fetch_vld = pick_found;
                fetch_tid = pick_idx;
            end
            SEL_HOLD: begin
                fetch_vld = thr_ready[cur_q] && !miss_evt;
                fetch_tid = cur_q;
            end
            SEL_DRAIN: begin
                drain_req = 1'b1;
            end
            SEL_SWAP: begin
                pick_start = tid_inc(cur_q);
                fetch_vld  = pick_found;
                fetch_tid  = pick_idx;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/mt_fetch_sel.sv
module mt_fetch_sel
    import mt_fetch_pkg::*;
#(
    parameter int              N_THREADS    = 4,
    parameter int              TID_W        = $clog2(N_THREADS),
    parameter int              PC_W         = 32,
    parameter int              ILEN_BYTES   = 4,
    parameter logic [PC_W-1:0] START_BASE   = '0,
    parameter logic [PC_W-1:0] START_STRIDE = PC_W'(32'h0000_1000)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coarse_mode,
    input  logic [N_THREADS-1:0] thr_ready,
    input  logic                 miss_evt,
    input  logic                 pipe_empty,
    input  logic                 redir_vld,
    input  logic [TID_W-1:0]     redir_tid,
    input  logic [PC_W-1:0]      redir_pc,
    output logic                 fetch_vld,
    output logic [TID_W-1:0]     fetch_tid,
    output logic [PC_W-1:0]      fetch_pc,
    output logic                 drain_req
);

    logic                      pick_found;
    logic [TID_W-1:0]          pick_idx;
    logic [TID_W-1:0]          pick_start;
    sel_state_e                fsm_state;
    logic [N_THREADS*PC_W-1:0] pc_flat;

    mt_rr_pick #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_pick (
        .req   (thr_ready),
        .start (pick_start),
        .found (pick_found),
        .idx   (pick_idx)
    );

    mt_sel_fsm #(
        .N_THREADS (N_THREADS),
        .TID_W     (TID_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .coarse_mode (coarse_mode),
        .thr_ready   (thr_ready),
        .miss_evt    (miss_evt),
        .pipe_empty  (pipe_empty),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .pick_start  (pick_start),
        .fetch_vld   (fetch_vld),
        .fetch_tid   (fetch_tid),
        .drain_req   (drain_req),
        .state_o     (fsm_state)
    );

    mt_pc_bank #(
        .N_THREADS    (N_THREADS),
        .TID_W        (TID_W),
        .PC_W         (PC_W),
        .ILEN_BYTES   (ILEN_BYTES),
        .START_BASE   (START_BASE),
        .START_STRIDE (START_STRIDE)
    ) u_pcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_vld   (fetch_vld),
        .inc_tid   (fetch_tid),
        .redir_vld (redir_vld),
        .redir_tid (redir_tid),
        .redir_pc  (redir_pc),
        .rd_tid    (fetch_tid),
        .rd_pc     (fetch_pc),
        .pc_flat   (pc_flat)
    );

endmodule

// File: rtl/mt_fetch_sel_chk.sv
module mt_fetch_sel_chk
    import mt_fetch_pkg::*;
#(
    parameter int N_THREADS  = 4,
    parameter int TID_W      = $clog2(N_THREADS),
    parameter int PC_W       = 32,
    parameter int ILEN_BYTES = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      coarse_mode,
    input logic [N_THREADS-1:0]      thr_ready,
    input logic                      miss_evt,
    input logic                      pipe_empty,
    input logic                      redir_vld,
    input logic [TID_W-1:0]          redir_tid,
    input logic [PC_W-1:0]           redir_pc,
    input logic                      fetch_vld,
    input logic [TID_W-1:0]          fetch_tid,
    input logic [PC_W-1:0]           fetch_pc,
    input logic                      drain_req,
    input logic [N_THREADS*PC_W-1:0] pc_flat,
    input sel_state_e                fsm_state
);

    // Last cycle's grant and redirect, held for the next-edge checks
    logic             inc_q, rdr_q, hit_q;
    logic [TID_W-1:0] inc_tid_q, rdr_tid_q;
    logic [PC_W-1:0]  inc_pc_q, rdr_pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_q     <= 1'b0;
            rdr_q     <= 1'b0;
            hit_q     <= 1'b0;
            inc_tid_q <= '0;
            rdr_tid_q <= '0;
            inc_pc_q  <= '0;
            rdr_pc_q  <= '0;
        end else begin
            inc_q     <= fetch_vld;
            inc_tid_q <= fetch_tid;
            inc_pc_q  <= fetch_pc;
            rdr_q     <= redir_vld && (32'(redir_tid) < N_THREADS);
            rdr_tid_q <= redir_tid;
            rdr_pc_q  <= redir_pc;
            hit_q     <= redir_vld && (redir_tid == fetch_tid);
        end
    end

    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |-> ((32'(fetch_tid) < N_THREADS) && thr_ready[fetch_tid]));

    p_idle_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_ready == '0) |-> !fetch_vld);

    p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_q && !hit_q) |->
            (pc_flat[inc_tid_q*PC_W +: PC_W] == inc_pc_q + PC_W'(ILEN_BYTES)));

    p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_q |-> (pc_flat[rdr_tid_q*PC_W +: PC_W] == rdr_pc_q));

    p_miss_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == SEL_FINE && miss_evt) |=> !drain_req);

    p_owner_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == SEL_HOLD && $past(fsm_state) == SEL_HOLD
            && fetch_vld && $past(fetch_vld)) |-> $stable(fetch_tid));

    p_drain_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && !pipe_empty) |=> drain_req);

    p_drain_no_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> !fetch_vld);

    p_refill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && pipe_empty) |=> (!drain_req && fsm_state == SEL_SWAP));

endmodule

bind mt_fetch_sel mt_fetch_sel_chk #(
    .N_THREADS  (N_THREADS),
    .TID_W      (TID_W),
    .PC_W       (PC_W),
    .ILEN_BYTES (ILEN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .coarse_mode (coarse_mode),
    .thr_ready   (thr_ready),
    .miss_evt    (miss_evt),
    .pipe_empty  (pipe_empty),
    .redir_vld   (redir_vld),
    .redir_tid   (redir_tid),
    .redir_pc    (redir_pc),
    .fetch_vld   (fetch_vld),
    .fetch_tid   (fetch_tid),
    .fetch_pc    (fetch_pc),
    .drain_req   (drain_req),
    .pc_flat     (pc_flat),
    .fsm_state   (fsm_state)
);

// File: tb/mt_fetch_sel_bench.sv
module mt_fetch_sel_bench;

    localparam int              N      = 3;
    localparam int              TW     = 2;
    localparam int              PW     = 16;
    localparam int              ILEN   = 4;
    localparam logic [PW-1:0]   BASE   = 16'h0100;
    localparam logic [PW-1:0]   STRIDE = 16'h0040;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          coarse_mode;
    logic [N-1:0]  thr_ready;
    logic          miss_evt;
    logic          pipe_empty;
    logic          redir_vld;
    logic [TW-1:0] redir_tid;
    logic [PW-1:0] redir_pc;
    logic          fetch_vld;
    logic [TW-1:0] fetch_tid;
    logic [PW-1:0] fetch_pc;
    logic          drain_req;

    always #5 clk = ~clk;

    mt_fetch_sel #(
        .N_THREADS    (N),
        .TID_W        (TW),
        .PC_W         (PW),
        .ILEN_BYTES   (ILEN),
        .START_BASE   (BASE),
        .START_STRIDE (STRIDE)
    ) u_mt_fetch_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .coarse_mode (coarse_mode),
        .thr_ready   (thr_ready),
        .miss_evt    (miss_evt),
        .pipe_empty  (pipe_empty),
        .redir_vld   (redir_vld),
        .redir_tid   (redir_tid),
        .redir_pc    (redir_pc),
        .fetch_vld   (fetch_vld),
        .fetch_tid   (fetch_tid),
        .fetch_pc    (fetch_pc),
        .drain_req   (drain_req)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Reference model: 0 FINE, 1 HOLD, 2 DRAIN, 3 SWAP
    int            m_state;
    int            m_ptr;
    int            m_cur;
    logic [PW-1:0] m_pc [N];

    function automatic int pick_from(input int start, input logic [N-1:0] rdy);
        for (int k = 0; k < N; k++) begin
            int p;
            p = (start + k) % N;
            if (rdy[p]) return p;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_state = 0;
        m_ptr   = 0;
        m_cur   = 0;
        for (int i = 0; i < N; i++) m_pc[i] = BASE + PW'(i) * STRIDE;
    endtask

    task automatic step(input string tag);
        int            e_idx;
        logic          e_vld;
        logic          e_drn;
        logic [PW-1:0] e_pc;
        string         t;
        int            old_ptr;
        #1;
        e_idx = -1;
        e_vld = 1'b0;
        e_drn = 1'b0;
        case (m_state)
            0: e_idx = pick_from(m_ptr, thr_ready);
            1: e_idx = (thr_ready[m_cur] && !miss_evt) ? m_cur : -1;
            2: e_drn = 1'b1;
            default: e_idx = pick_from((m_cur + 1) % N, thr_ready);
        endcase
        e_vld = (e_idx >= 0);
        e_pc  = e_vld ? m_pc[e_idx] : '0;
        t = tag;
        if (t == "") begin
            case (m_state)
                0: t = "R2";
                1: t = "R7";
                2: t = "R8";
                default: t = "R9";
            endcase
        end
        n_vec++;
        if (fetch_vld !== e_vld || drain_req !== e_drn ||
            (e_vld && (fetch_tid !== TW'(e_idx) || fetch_pc !== e_pc))) begin
            n_bad++;
            $display("FAIL %s: vld=%0b tid=%0d pc=%h drain=%0b expected vld=%0b tid=%0d pc=%h drain=%0b",
                     t, fetch_vld, fetch_tid, fetch_pc, drain_req,
                     e_vld, e_idx, e_pc, e_drn);
        end
        @(posedge clk);
        old_ptr = m_ptr;
        case (m_state)
            0: begin
                if (e_vld) m_ptr = (e_idx + 1) % N;
                if (coarse_mode) begin
                    m_cur   = e_vld ? e_idx : old_ptr;
                    m_state = 1;
                end
            end
            1: begin
                if (miss_evt) m_state = 2;
                else if (!coarse_mode) begin
                    m_state = 0;
                    m_ptr   = (m_cur + 1) % N;
                end
            end
            2: if (pipe_empty) m_state = 3;
            default: begin
                if (e_vld) begin
                    m_cur   = e_idx;
                    m_ptr   = (e_idx + 1) % N;
                    m_state = coarse_mode ? 1 : 0;
                end
            end
        endcase
        if (e_vld) m_pc[e_idx] = m_pc[e_idx] + PW'(ILEN);
        if (redir_vld && int'(redir_tid) < N) m_pc[redir_tid] = redir_pc;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic coarse);
        rst_n       = 1'b0;
        coarse_mode = coarse;
        thr_ready   = '1;
        miss_evt    = 1'b0;
        pipe_empty  = 1'b0;
        redir_vld   = 1'b0;
        redir_tid   = '0;
        redir_pc    = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);

        // Reset state and start PCs: tids 0,1,2 at 0x100,0x140,0x180 (R1)
        do_reset(1'b0);
        repeat (3) step("R1");
        repeat (2) step("R2");

        // Stalled thread 1 skipped, 0 and 2 interleave (R2)
        thr_ready = 3'b101;
        repeat (4) step("R2");
        thr_ready = 3'b010;
        repeat (2) step("R2");

        // Nothing ready, then resume from the held pointer (R3)
        thr_ready = 3'b000;
        repeat (3) step("R3");
        thr_ready = 3'b111;
        repeat (3) step("R3");

        // PC advance per grant (R4)
        repeat (3) step("R4");

        // Redirect, including one that collides with a grant (R5)
        redir_vld = 1'b1; redir_tid = 2'd1; redir_pc = 16'h2000;
        step("R5");
        redir_tid = 2'd0; redir_pc = 16'h3000;
        step("R5");
        redir_vld = 1'b0;
        repeat (3) step("R5");
        redir_vld = 1'b1; redir_tid = 2'd3; redir_pc = 16'hDEAD;
        step("R5");
        redir_vld = 1'b0;
        repeat (3) step("R5");

        // Miss ignored in fine mode (R6)
        miss_evt = 1'b1;
        repeat (3) step("R6");
        miss_evt = 1'b0;

        // Coarse mode from reset
        do_reset(1'b1);
        step("R10");
        repeat (3) step("R7");
        thr_ready = 3'b110;
        repeat (2) step("R7");
        thr_ready = 3'b111;
        miss_evt = 1'b1;
        step("R8");
        miss_evt = 1'b0;
        repeat (3) step("R8");
        pipe_empty = 1'b1;
        step("R8");
        pipe_empty = 1'b0;
        thr_ready  = 3'b001;
        step("R9");
        repeat (2) step("R7");
        miss_evt = 1'b1;
        step("R8");
        miss_evt   = 1'b0;
        pipe_empty = 1'b1;
        step("R8");
        thr_ready = 3'b000;
        repeat (2) step("R9");
        thr_ready = 3'b100;
        step("R9");
        pipe_empty = 1'b0;
        thr_ready  = 3'b111;
        step("R7");

        // Mode switching both ways (R10)
        coarse_mode = 1'b0;
        step("R10");
        repeat (3) step("R10");
        coarse_mode = 1'b1;
        repeat (3) step("R10");

        // Constrained random
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(63) == 0) coarse_mode = ~coarse_mode;
            thr_ready  = N'($urandom);
            if ($urandom_range(5) == 0) thr_ready = '0;
            miss_evt   = ($urandom_range(15) == 0);
            pipe_empty = ($urandom_range(2) == 0);
            redir_vld  = ($urandom_range(7) == 0);
            redir_tid  = TW'($urandom);
            redir_pc   = PW'($urandom);
            step("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule